// File: doc/BRIEF.md
# Line-Phase Skew Corrector

This block removes the sudden horizontal jumps that appear in trick-play video, where each head pass can land the picture a fraction of a line early or late. It runs a line-rate reference counter and notes where each separated sync edge falls against that reference. The position is rounded to one of five equal phase bins per line. Once the same bin has been seen on two lines in a row, the read delay of a line memory is retuned so that the video sync comes out at a fixed reference phase.

A level code from an external three-level comparator is decoded into a vertical mask and a killer flag, with a polarity bit that selects which level means which. While the mask is active, bin detection is frozen and the reference runs at its nominal line period. In correction mode the sync output carries a regenerated line pulse aligned to the corrected video, with the mask optionally ORed in. In pass mode the video goes straight through and the sync output is the input sync delayed by a fixed number of register stages.

Top module: `skew_corrector`

## Requirements
- R1: While rst_ni is low, vid_o and sync_o are 0, and killer_o is 0 when lvl_i is 0.
- R2: lvl_i codes are 0 low, 1 mid, 2 or 3 high. With pol_sel_i=0 high means mask and mid means killer; with pol_sel_i=1 mid means mask and high means killer. killer_o shows the decoded killer flag.
- R3: The reference counter runs 0..LINE_CLKS-1. A sync edge is the first cycle in which the registered csync_i is 1 after a 0, and it is binned as b = floor(count/(LINE_CLKS/BINS)). The target delay is ((BINS-b) mod BINS)*(LINE_CLKS/BINS) clocks. With skew_en_i=1, a vid_i sample taken at clock edge j appears on vid_o in the cycle after edge j+D, where D is the applied delay.
- R4: The delay is updated only when an unmasked edge has the same bin as the unmasked edge just before it. A single edge in a different bin leaves the delay unchanged.
- R5: While the mask is active, sync edges are ignored, the reference advances by exactly one per clock, and the bin history is cleared. After the mask ends, two matching edges are needed again.
- R6: An unmasked edge whose offset within its bin is above BIN/2 holds the reference count for one clock. An edge whose offset is below BIN/2 advances the count by two for one clock.
- R7: With skew_en_i=1 and no mask mixed in, sync_o is high for exactly HD_W clocks, starting in the cycle where the reference count equals BIN/2. This is the phase at which the corrected video's sync edge emerges.
- R8: With skew_en_i=1 and mix_pv_i=1, sync_o is also high whenever the decoded mask is active. With mix_pv_i=0 the mask does not appear on sync_o.
- R9: With skew_en_i=0, vid_o equals vid_i delayed by one clock. sync_o equals csync_i after SYNC_DLY register stages, and the line pulse is absent.
- R10: A csync_i pulse lasting a single clock is accepted as a sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock (four times subcarrier) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csync_i | input | 1 | Separated composite sync, active high |
| lvl_i | input | 2 | Three-level control input code |
| pol_sel_i | input | 1 | Swaps mask/killer meaning of mid and high |
| skew_en_i | input | 1 | 1 = correction mode, 0 = pass mode |
| mix_pv_i | input | 1 | ORs the mask into the line pulse |
| vid_i | input | DATA_W | Video sample stream |
| vid_o | output | DATA_W | Corrected video |
| sync_o | output | 1 | Line pulse or delayed input sync |
| killer_o | output | 1 | Decoded killer flag |

## Verification
The bench builds the block with LINE_CLKS=40, BINS=5, HD_W=6 and SYNC_DLY=3. This gives 8-clock bins, a 32-word memory and 40-clock lines. Every bin, each one-clock phase nudge in both directions, masked and unmasked lines, the history clear, and the short pass-mode sync delay are then reached within a few dozen lines. A ramp on vid_i makes the applied delay readable on every cycle as a plain difference.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_OVER = 2'd3
  } lvl_e;

  typedef struct packed {
    logic pv;
    logic killer;
  } ctl_t;

  function automatic ctl_t decode_lvl(input logic [1:0] lvl, input logic pol);
    ctl_t c;
    logic is_mid, is_high;
    is_mid   = (lvl == LVL_MID);
    is_high  = lvl[1];
    c.pv     = pol ? is_mid : is_high;
    c.killer = pol ? is_high : is_mid;
    return c;
  endfunction
endpackage

// File: rtl/skew_line_ref.sv
module skew_line_ref #(
  parameter int LINE_CLKS = 910,
  parameter int HD_START  = 91,
  parameter int HD_W      = 63,
  localparam int CW       = $clog2(LINE_CLKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          skip_i,
  output logic [CW-1:0] cnt_o,
  output logic          hd_o
);
  logic [CW:0] sum;
  logic [CW:0] nxt;

  always_comb begin
    sum = {1'b0, cnt_o} + (hold_i ? (CW+1)'(0) : skip_i ? (CW+1)'(2) : (CW+1)'(1));
    nxt = (sum >= (CW+1)'(LINE_CLKS)) ? sum - (CW+1)'(LINE_CLKS) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= nxt[CW-1:0];
  end

  assign hd_o = (cnt_o >= CW'(HD_START)) && (cnt_o < CW'(HD_START + HD_W));
endmodule

// File: rtl/skew_phase_det.sv
module skew_phase_det #(
  parameter int LINE_CLKS = 910,
  parameter int BINS      = 5,
  localparam int CW       = $clog2(LINE_CLKS),
  localparam int BIN_CLKS = LINE_CLKS / BINS,
  localparam int HALF     = BIN_CLKS / 2,
  localparam int MAX_DLY  = (BINS - 1) * BIN_CLKS,
  localparam int DLY_W    = $clog2(MAX_DLY + 1),
  localparam int BW       = $clog2(BINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csync_i,
  input  logic             mask_i,
  input  logic [CW-1:0]    cnt_i,
  output logic             edge_o,
  output logic             hold_o,
  output logic             skip_o,
  output logic [DLY_W-1:0] dly_o
);
  logic          sync_q, sync_qq;
  logic [BW-1:0] bin, last_bin;
  logic          have_last;
  logic [CW-1:0] fine;
  logic [DLY_W-1:0] tgt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      sync_qq <= 1'b0;
    end else begin
      sync_q  <= csync_i;
      sync_qq <= sync_q;
    end
  end

  assign edge_o = sync_q & ~sync_qq & ~mask_i;

  always_comb begin
    bin = '0;
    for (int k = 1; k < BINS; k++)
      if (cnt_i >= CW'(k * BIN_CLKS)) bin = BW'(k);
    fine = cnt_i - CW'(int'(bin) * BIN_CLKS);
    tgt  = (bin == '0) ? '0 : DLY_W'((BINS - int'(bin)) * BIN_CLKS);
  end

  assign hold_o = edge_o && (fine > CW'(HALF));
  assign skip_o = edge_o && (fine < CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_bin  <= '0;
      have_last <= 1'b0;
      dly_o     <= '0;
    end else if (mask_i) begin
      have_last <= 1'b0;
    end else if (edge_o) begin
      have_last <= 1'b1;
      last_bin  <= bin;
      if (have_last && last_bin == bin) dly_o <= tgt;
    end
  end
endmodule

// File: rtl/skew_line_mem.sv
module skew_line_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 728,
  localparam int AW    = $clog2(DEPTH),
  localparam int DLY_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] vid_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic [DATA_W-1:0] vid_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp;
  logic [AW-1:0]     rp;

  always_comb begin
    int r;
    r = int'(wp) - int'(dly_i);
    if (r < 0) r = r + DEPTH;
    rp = AW'(r);
  end

  always_ff @(posedge clk_i) mem[wp] <= vid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp    <= '0;
      vid_o <= '0;
    end else begin
      wp    <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      vid_o <= (dly_i == '0) ? vid_i : mem[rp];
    end
  end
endmodule

// File: rtl/skew_corrector.sv
module skew_corrector #(
  parameter int LINE_CLKS = 910,
  parameter int BINS      = 5,
  parameter int HD_W      = 63,
  parameter int SYNC_DLY  = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csync_i,
  input  logic [1:0]        lvl_i,
  input  logic              pol_sel_i,
  input  logic              skew_en_i,
  input  logic              mix_pv_i,
  input  logic [DATA_W-1:0] vid_i,
  output logic [DATA_W-1:0] vid_o,
  output logic              sync_o,
  output logic              killer_o
);
  import skew_pkg::*;

  localparam int CW       = $clog2(LINE_CLKS);
  localparam int BIN_CLKS = LINE_CLKS / BINS;
  localparam int HALF     = BIN_CLKS / 2;
  localparam int MAX_DLY  = (BINS - 1) * BIN_CLKS;
  localparam int DLY_W    = $clog2(MAX_DLY + 1);

  ctl_t             ctl;
  logic             pv_w;
  logic             edge_ok, hold, skip, hd;
  logic [CW-1:0]    cnt;
  logic [DLY_W-1:0] dly, dly_eff;
  logic [SYNC_DLY-1:0] sdly;

  assign ctl      = decode_lvl(lvl_i, pol_sel_i);
  assign pv_w     = ctl.pv;
  assign killer_o = ctl.killer;

  skew_line_ref #(.LINE_CLKS(LINE_CLKS), .HD_START(HALF), .HD_W(HD_W)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .skip_i(skip),
    .cnt_o(cnt), .hd_o(hd)
  );

  skew_phase_det #(.LINE_CLKS(LINE_CLKS), .BINS(BINS)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .csync_i(csync_i), .mask_i(pv_w),
    .cnt_i(cnt), .edge_o(edge_ok), .hold_o(hold), .skip_o(skip), .dly_o(dly)
  );

  assign dly_eff = skew_en_i ? dly : '0;

  skew_line_mem #(.DATA_W(DATA_W), .DEPTH(MAX_DLY)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .vid_i(vid_i), .dly_i(dly_eff), .vid_o(vid_o)
  );

  generate
    if (SYNC_DLY == 1) begin : g_sd1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sdly <= '0;
        else         sdly <= csync_i;
    end else begin : g_sdn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sdly <= '0;
        else         sdly <= {sdly[SYNC_DLY-2:0], csync_i};
    end
  endgenerate

  assign sync_o = skew_en_i ? (hd | (mix_pv_i & pv_w)) : sdly[SYNC_DLY-1];
endmodule

// File: rtl/skew_corrector_chk.sv
module skew_corrector_chk #(
  parameter int LINE_CLKS = 910,
  parameter int BIN_CLKS  = 182,
  parameter int CW        = 10,
  parameter int DLY_W     = 10,
  parameter int DATA_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              skew_en_i,
  input logic              mix_pv_i,
  input logic              pv_i,
  input logic              edge_i,
  input logic [CW-1:0]     cnt_i,
  input logic [DLY_W-1:0]  dly_i,
  input logic [DATA_W-1:0] vid_i,
  input logic [DATA_W-1:0] vid_o,
  input logic              sync_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  AST_DLY_FROZEN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_i |=> $stable(dly_i)); // R5
  AST_DLY_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$stable(dly_i)) |-> $past(edge_i)); // R4
  AST_DLY_ON_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(dly_i) % BIN_CLKS) == 0); // R3
  AST_FREERUN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && pv_i) |=> (cnt_i == (($past(cnt_i) == CW'(LINE_CLKS - 1)) ? '0 : $past(cnt_i) + 1'b1))); // R5
  AST_PV_MIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skew_en_i && mix_pv_i && pv_i) |-> sync_o); // R8
  AST_VID_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !skew_en_i && $past(!skew_en_i)) |-> (vid_o == $past(vid_i))); // R9
endmodule

bind skew_corrector skew_corrector_chk #(
  .LINE_CLKS(LINE_CLKS), .BIN_CLKS(BIN_CLKS), .CW(CW), .DLY_W(DLY_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .skew_en_i(skew_en_i), .mix_pv_i(mix_pv_i),
  .pv_i(pv_w), .edge_i(edge_ok), .cnt_i(cnt), .dly_i(dly),
  .vid_i(vid_i), .vid_o(vid_o), .sync_o(sync_o)
);

// File: tb/skew_corrector_test.sv
`timescale 1ns/1ps
module skew_corrector_test;
  localparam int LINE = 40;
  localparam int BINS = 5;
  localparam int HDW  = 6;
  localparam int SDLY = 3;
  localparam int DW   = 8;
  localparam int BIN  = LINE / BINS;
  localparam int HALF = BIN / 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          csync_i = 1'b0;
  logic [1:0]    lvl_i = 2'd0;
  logic          pol_sel_i = 1'b0;
  logic          skew_en_i = 1'b0;
  logic          mix_pv_i = 1'b0;
  logic [DW-1:0] vid_i = '0;
  logic [DW-1:0] vid_o;
  logic          sync_o;
  logic          killer_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int zb = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  skew_corrector #(.LINE_CLKS(LINE), .BINS(BINS), .HD_W(HDW), .SYNC_DLY(SDLY), .DATA_W(DW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .csync_i(csync_i), .lvl_i(lvl_i),
    .pol_sel_i(pol_sel_i), .skew_en_i(skew_en_i), .mix_pv_i(mix_pv_i),
    .vid_i(vid_i), .vid_o(vid_o), .sync_o(sync_o), .killer_o(killer_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    cyc++;
    vid_i = cyc[DW-1:0];
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) tick();
  endtask

  task automatic run_line(input int x, input int w);
    while (zb + x - 1 <= cyc) zb += LINE;
    wait_to(zb + x - 1);
    csync_i = 1'b1;
    repeat (w) tick();
    csync_i = 1'b0;
    zb += LINE;
  endtask

  task automatic chk_vid(input string req, input int d);
    check(req, int'(vid_o), (cyc - 1 - d) & 255);
  endtask

  task automatic chk_hd(input string req);
    while (zb + HALF - 1 <= cyc) zb += LINE;
    wait_to(zb + HALF - 1);
    check(req, int'(sync_o), 0);
    tick();
    check(req, int'(sync_o), 1);
    wait_to(zb + HALF + HDW - 1);
    check(req, int'(sync_o), 1);
    tick();
    check(req, int'(sync_o), 0);
  endtask

  task automatic goto_hd_low();
    while (zb + HALF + HDW + 2 <= cyc) zb += LINE;
    wait_to(zb + HALF + HDW + 2);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    check("R1 vid", int'(vid_o), 0);
    check("R1 sync", int'(sync_o), 0);
    check("R1 killer", int'(killer_o), 0);
    rst_ni = 1'b1;
    skew_en_i = 1'b1;
  endtask

  task automatic t_lock();
    int h;
    h = -1;
    for (int i = 0; i < 3 * LINE && h < 0; i++) begin
      tick();
      if (sync_o) h = cyc;
    end
    check("R7 pulse found", int'(h >= 0), 1);
    zb = h - HALF + LINE;
    run_line(HALF, 2);
    run_line(HALF, 2);
    chk_hd("R7 width/phase");
  endtask

  task automatic t_nudge();
    run_line(HALF + 1, 1);   // late by one: reference held
    zb += 1;
    chk_hd("R6 hold");
    run_line(HALF - 1, 1);   // early by one: reference skips
    zb -= 1;
    chk_hd("R6 skip");
    wait_to(cyc + 3);
    chk_vid("R3 bin0 delay", 0);
  endtask

  task automatic t_bins();
    run_line(2 * BIN + HALF, 1);   // R10 single-clock pulses
    wait_to(cyc + 5);
    chk_vid("R4 first bin2 line", 0);
    run_line(2 * BIN + HALF, 1);
    wait_to(cyc + 5);
    chk_vid("R3 bin2 delay", 3 * BIN);
    chk_hd("R7 aligned after bin2");
    run_line(4 * BIN + HALF, 1);
    wait_to(cyc + 3);
    chk_vid("R4 glitch ignored", 3 * BIN);
    run_line(2 * BIN + HALF, 1);
    wait_to(cyc + 3);
    chk_vid("R4 no update after glitch", 3 * BIN);
    run_line(4 * BIN + HALF, 1);
    run_line(4 * BIN + HALF, 1);
    wait_to(cyc + 3);
    chk_vid("R3 bin4 delay", BIN);
  endtask

  task automatic t_mask();
    run_line(3 * BIN + HALF, 1);
    wait_to(cyc + 3);
    chk_vid("R4 bin3 single", BIN);
    lvl_i = 2'd2;
    run_line(3 * BIN + HALF + 1, 1);
    run_line(3 * BIN + HALF + 1, 1);
    wait_to(cyc + 3);
    chk_vid("R5 masked edges ignored", BIN);
    chk_hd("R5 no nudge under mask");
    goto_hd_low();
    check("R8 mix off", int'(sync_o), 0);
    mix_pv_i = 1'b1;
    tick();
    check("R8 mix on", int'(sync_o), 1);
    mix_pv_i = 1'b0;
    lvl_i = 2'd0;
    run_line(3 * BIN + HALF, 1);
    wait_to(cyc + 3);
    chk_vid("R5 history cleared", BIN);
    run_line(3 * BIN + HALF, 1);
    wait_to(cyc + 3);
    chk_vid("R3 bin3 delay", 2 * BIN);
  endtask

  task automatic t_levels();
    goto_hd_low();
    mix_pv_i = 1'b1;
    pol_sel_i = 1'b0; lvl_i = 2'd1; tick();
    check("R2 pol0 mid killer", int'(killer_o), 1);
    check("R2 pol0 mid not mask", int'(sync_o), 0);
    pol_sel_i = 1'b1; tick();
    check("R2 pol1 mid mask", int'(sync_o), 1);
    check("R2 pol1 mid no killer", int'(killer_o), 0);
    lvl_i = 2'd2; tick();
    check("R2 pol1 high killer", int'(killer_o), 1);
    check("R2 pol1 high not mask", int'(sync_o), 0);
    lvl_i = 2'd3; pol_sel_i = 1'b0; tick();
    check("R2 pol0 code3 mask", int'(sync_o), 1);
    check("R2 pol0 code3 no killer", int'(killer_o), 0);
    lvl_i = 2'd0; mix_pv_i = 1'b0; pol_sel_i = 1'b0;
    tick();
  endtask

  task automatic t_bypass();
    skew_en_i = 1'b0;
    tick();
    tick();
    chk_vid("R9 video bypass", 0);
    run_line(HALF, 1);
    tick();
    check("R9 sync stage2", int'(sync_o), 0);
    tick();
    check("R9 sync delayed", int'(sync_o), 1);
    tick();
    check("R9 sync width", int'(sync_o), 0);
    wait_to(zb + HALF + 1);
    check("R9 no line pulse", int'(sync_o), 0);
    skew_en_i = 1'b1;
    tick();
    tick();
    chk_vid("R3 delay restored", 2 * BIN);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_nudge();
    t_bins();
    t_mask();
    t_levels();
    t_bypass();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule